// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block chooses which of the pending exceptions the processor should take next. It also decides whether that choice may interrupt the handler that is running now. Each exception has a number. System exceptions use numbers 1 to 15, and external interrupt `k` uses number `16 + k`. Numbers 1, 2 and 3 carry fixed levels -3, -2 and -1. Every other exception uses an 8-bit configured priority, and a smaller value means a more urgent exception.

A 3-bit grouping field `P` splits each 8-bit priority into two parts. Bits `[7:P+1]` form the group priority and bits `[P:0]` form the sub-priority. Only the group priority decides preemption. The full priority value, then the exception number, orders the pending requests.

The arbiter combines one candidate per exception into a reduction tree in a single cycle. It registers the winner, a valid flag and a preempt flag. Stacking, vector fetch and the storage of the priority bytes live outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: When no pending bit with a number from 1 upward is set, `req_valid_o` is 0 and `exc_num_o` is 0 one cycle later.
- R2: Exception numbers 1, 2 and 3 have fixed levels -3, -2 and -1. They win over every configurable exception, and their priority bytes have no effect.
- R3: Among pending configurable exceptions, the one with the numerically smallest 8-bit priority wins. Within one group, the smaller sub-priority wins.
- R4: When pending exceptions have equal priority, the lowest exception number wins. Pending bit 0 is ignored.
- R5: The group priority of the winner is `prio >> (P+1)`, which has `7-P` bits. `preempt_o` is 1 when this group is strictly smaller than the group of the active priority.
- R6: An equal group never preempts, whatever the exception number. With `P = 7`, no configurable exception preempts a configurable active level.
- R7: `act_prio_i` is 10-bit signed. The values -3, -2 and -1 are the fixed levels, 0 to 255 are configurable levels, and 256 or more means idle. When the block is idle, any valid winner preempts.
- R8: `preempt_o` is 1 only while `req_valid_o` is 1.
- R9: All outputs are registered with one cycle of latency. Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_EXC | Pending flag per exception number (bit 0 unused) |
| prio_i | input | 8*NUM_EXC | Priority byte of exception `n` at bits `[8n+7:8n]` |
| group_sel_i | input | 3 | Grouping boundary `P` |
| act_prio_i | input | 10 (signed) | Priority of the running handler; 256 or more means idle |
| req_valid_o | output | 1 | A request is pending |
| exc_num_o | output | 8 | Winning exception number, or 0 |
| preempt_o | output | 1 | The winner may interrupt the active handler |

## Verification
The hardest case to reach is a set of pending requests with equal group and equal full priority, together with an active level in that same group. This case tests the tie order and the rule that an equal group never preempts at the same time. Random priorities alone almost never produce it. The random stimulus therefore draws priorities from a small pool of group and sub values so that collisions are frequent, and sweeps every grouping value. Directed cases then place exactly equal priorities on distant exception numbers and exercise the idle, fixed-level and `P = 7` boundaries.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W    = 8;
    localparam int EXC_W     = 8;
    localparam int LVL_W     = 9;   // biased level: fixed 0..2, configurable 3..258
    localparam int GRP_W     = 10;  // signed group value
    localparam int SYS_SLOTS = 16;
    localparam int FIXED_TOP = 3;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [EXC_W-1:0] num;
    } cand_t;

    // Biased ordering level: fixed exceptions below all configurable ones.
    function automatic logic [LVL_W-1:0] level_of(input int unsigned num,
                                                  input logic [PRIO_W-1:0] prio);
        if (num <= FIXED_TOP)
            return LVL_W'(num - 1);
        return LVL_W'(prio) + LVL_W'(FIXED_TOP);
    endfunction

    // Lower key wins; lower index side wins ties on level via number compare.
    function automatic cand_t pick(input cand_t a, input cand_t b);
        if (a.valid && (!b.valid || {a.level, a.num} <= {b.level, b.num}))
            return a;
        return b;
    endfunction

    // Group value of a biased level under grouping boundary sel.
    function automatic logic signed [GRP_W-1:0] level_group(input logic [LVL_W-1:0] lvl,
                                                           input logic [2:0] sel);
        logic [GRP_W-1:0] t;
        t = {1'b0, lvl} - GRP_W'(FIXED_TOP);
        if (lvl < LVL_W'(FIXED_TOP))
            return $signed(t);
        return $signed((t >> sel) >> 1);
    endfunction

    // Group value of the active priority; idle maps above every group.
    function automatic logic signed [GRP_W-1:0] active_group(input logic signed [GRP_W-1:0] act,
                                                            input logic [2:0] sel);
        logic [GRP_W-1:0] u;
        u = act;
        if (act < 0)
            return act;
        if (act > 10'sd255)
            return 10'sd256;
        return $signed((u >> sel) >> 1);
    endfunction

endpackage

// File: rtl/irq_cand_gen.sv
module irq_cand_gen
    import irq_arb_pkg::*;
#(
    parameter int NUM_EXC = 48
) (
    input  logic [NUM_EXC-1:0]        pend_i,
    input  logic [NUM_EXC*PRIO_W-1:0] prio_i,
    output cand_t [NUM_EXC-1:0]       cand_o
);
    for (genvar i = 0; i < NUM_EXC; i++) begin : g_cand
        if (i == 0) begin : g_unused
            assign cand_o[i] = '0;
        end else begin : g_live
            assign cand_o[i].valid = pend_i[i];
            assign cand_o[i].level = level_of(i, prio_i[i*PRIO_W +: PRIO_W]);
            assign cand_o[i].num   = EXC_W'(i);
        end
    end
endmodule

// File: rtl/irq_min_tree.sv
module irq_min_tree
    import irq_arb_pkg::*;
#(
    parameter int N = 48
) (
    input  cand_t [N-1:0] cand_i,
    output cand_t         win_o
);
    localparam int DEPTH  = (N > 1) ? $clog2(N) : 0;
    localparam int LEAVES = 1 << DEPTH;

    cand_t node [1:2*LEAVES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[LEAVES+i] = cand_i[i];
        end else begin : g_pad
            assign node[LEAVES+i] = '0;
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        assign node[n] = pick(node[2*n], node[2*n+1]);
    end

    assign win_o = node[1];

    always_comb begin
        a_r4_tie_low_number: assert (!(node[2].valid && node[3].valid &&
                                       node[2].level == node[3].level) ||
                                     win_o.num == node[2].num || LEAVES < 2);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_IRQ   = 32,
    localparam int NUM_EXC = SYS_SLOTS + N_IRQ
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_EXC-1:0]        pend_i,
    input  logic [NUM_EXC*PRIO_W-1:0] prio_i,
    input  logic [2:0]                group_sel_i,
    input  logic signed [GRP_W-1:0]   act_prio_i,
    output logic                      req_valid_o,
    output logic [EXC_W-1:0]          exc_num_o,
    output logic                      preempt_o
);
    cand_t [NUM_EXC-1:0] cand;
    cand_t               win;
    logic signed [GRP_W-1:0] win_grp, act_grp;

    irq_cand_gen #(.NUM_EXC(NUM_EXC)) u_gen (
        .pend_i (pend_i),
        .prio_i (prio_i),
        .cand_o (cand)
    );

    irq_min_tree #(.N(NUM_EXC)) u_tree (
        .cand_i (cand),
        .win_o  (win)
    );

    assign win_grp = level_group(win.level, group_sel_i);
    assign act_grp = active_group(act_prio_i, group_sel_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_valid_o <= 1'b0;
            exc_num_o   <= '0;
            preempt_o   <= 1'b0;
        end else begin
            req_valid_o <= win.valid;
            exc_num_o   <= win.valid ? win.num : '0;
            preempt_o   <= win.valid && (win_grp < act_grp);
        end
    end

    // Checker state: inputs of the previous cycle.
    logic                      rst_d;
    logic [NUM_EXC-1:0]        pend_d;
    logic signed [GRP_W-1:0]   act_d;
    always_ff @(posedge clk_i) begin
        rst_d  <= rst_i;
        pend_d <= pend_i;
        act_d  <= act_prio_i;
    end

    a_r8_preempt_needs_valid: assert property (@(posedge clk_i) disable iff (rst_i)
        preempt_o |-> req_valid_o);
    a_r1_idle_number_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_o |-> exc_num_o == '0);
    a_r9_valid_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_d |-> req_valid_o == (|pend_d[NUM_EXC-1:1]));
    a_r3_winner_pending: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_d && req_valid_o) |-> pend_d[exc_num_o]);
    a_r2_reset_exc_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_d && pend_d[1]) |-> exc_num_o == EXC_W'(1));
    a_r7_idle_preempts: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rst_d && req_valid_o && act_d > 10'sd255) |-> preempt_o);
endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    localparam int N_IRQ = 32;
    localparam int NUM   = 16 + N_IRQ;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM-1:0]   pend = '0;
    logic [NUM*8-1:0] prio_flat = '0;
    logic [2:0]       sel = '0;
    logic signed [9:0] act_v = 10'sd256;
    logic             vld;
    logic [7:0]       num;
    logic             pre;

    int pr [NUM];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_arbiter #(.N_IRQ(N_IRQ)) u0 (
        .clk_i (clk), .rst_i (rst), .pend_i (pend), .prio_i (prio_flat),
        .group_sel_i (sel), .act_prio_i (act_v),
        .req_valid_o (vld), .exc_num_o (num), .preempt_o (pre)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic expect_out(output int ev, output int en, output int ep);
        int bl, lvl, wg, ag, a;
        ev = 0; en = 0; ep = 0; bl = 1 << 20;
        for (int e = 1; e < NUM; e++) begin
            if (pend[e]) begin
                lvl = (e <= 3) ? e - 4 : pr[e];
                if (lvl < bl) begin bl = lvl; en = e; ev = 1; end
            end
        end
        if (ev) begin
            wg = (bl < 0) ? bl : (bl >> (sel + 1));
            a  = int'(act_v);
            ag = (a < 0) ? a : (a > 255 ? 256 : (a >> (sel + 1)));
            ep = (wg < ag) ? 1 : 0;
        end
    endtask

    task automatic run(string tag);
        int ev, en, ep;
        for (int e = 0; e < NUM; e++) prio_flat[e*8 +: 8] = pr[e][7:0];
        expect_out(ev, en, ep);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid"}, int'(vld), ev);
        chk({tag, " number"}, int'(num), en);
        chk({tag, " preempt"}, int'(pre), ep);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < NUM; e++) pr[e] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid", int'(vld), 0);
        chk("R9 reset number", int'(num), 0);
        chk("R9 reset preempt", int'(pre), 0);
        rst = 1'b0;

        pend = '0; run("R1 empty");
        pend = '0; pend[0] = 1'b1; run("R4 bit0 ignored");

        // R2: fixed levels beat configurable priority 0, bytes of 1..3 are 0xFF
        pend = '0; pend[2] = 1'b1; pend[3] = 1'b1; pr[20] = 0; pend[20] = 1'b1;
        run("R2 nmi beats hardfault and irq");
        pend[1] = 1'b1; run("R2 reset wins");

        // R4: equal priority, lower number wins
        for (int e = 0; e < NUM; e++) pr[e] = 8'hFF;
        pend = '0; pr[20] = 8'h40; pr[17] = 8'h40; pend[20] = 1'b1; pend[17] = 1'b1;
        act_v = 10'sd256; run("R4 tie lowest number");

        // R3/R6: P=4 group [7:5]; same group, sub decides; equal group no preempt
        sel = 3'd4; pend = '0; pr[18] = 8'h47; pr[25] = 8'h41; pend[18] = 1'b1; pend[25] = 1'b1;
        act_v = 10'sd64; run("R3 R6 sub priority, equal group");
        act_v = 10'sd96; run("R5 higher group preempts");

        // R6: P=7 leaves no group bits
        sel = 3'd7; pend = '0; pr[30] = 0; pend[30] = 1'b1; act_v = 10'sd255;
        run("R6 no group bits");
        act_v = 10'sd300; run("R7 idle preempts");

        // R7: active fixed levels
        sel = 3'd0; pend = '0; pend[2] = 1'b1; act_v = -10'sd1; run("R7 nmi over hardfault");
        pend = '0; pend[3] = 1'b1; run("R7 hardfault vs itself");
        pend = '0; pend[40] = 1'b1; pr[40] = 0; run("R7 irq vs hardfault");

        // Random mix with colliding priorities
        for (int t = 0; t < 400; t++) begin
            sel = 3'($urandom_range(0, 7));
            for (int e = 0; e < NUM; e++) begin
                pr[e] = (($urandom_range(0, 3) * 64) + $urandom_range(0, 3) * 8) & 8'hFF;
                pend[e] = ($urandom_range(0, 7) == 0);
            end
            if ($urandom_range(0, 9) == 0) pend = '0;
            case ($urandom_range(0, 2))
                0: act_v = 10'($signed(-$urandom_range(1, 3)));
                1: act_v = 10'($urandom_range(0, 255));
                default: act_v = 10'($urandom_range(256, 511));
            endcase
            run("R3 R5 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule